// File: doc/BRIEF.md
# Subsystem Identification Register with Load Control

This block holds a 32-bit identification doubleword in configuration space. The vendor half lives in the low 16 bits at byte offset 40h and the device half in the high 16 bits at offset 42h. Software normally sees the doubleword as read-only. There are two ways to give it a value, and both are legal only at controlled moments.

Firmware can set a write-enable bit in a system control doubleword at offset 80h. It then writes the identifier with per-byte enables and clears the bit again. The second way is an external serial-memory reader. After every effective primary-bus reset the block requests one load, and it takes the first valid word it is given.

A suspend input masks the bus reset. While suspend is high, a reset pulse does not clear the identifier or the enable bit, and it does not start a new load. The serial two-wire engine that fetches the word sits outside this block.

Top module: `subsys_id_regs`

## Requirements
- R1: An effective reset (rst_bus_n low while suspend is low, sampled on a clock edge) clears the identifier to 0 and the write-enable bit to 0, and drives ee_load_req to 1.
- R2: cfg_rdata is combinational. With cfg_rd high and cfg_dwaddr equal to 10h (byte offset 40h), it shows the identifier in the same cycle, vendor in bits [15:0] and device in bits [31:16]. With cfg_rd low it is 0.
- R3: The control doubleword at cfg_dwaddr 20h (byte offset 80h) reads back the write-enable bit in bit 5 and 0 in every other bit. A write with cfg_be[0] high loads bit 5 from cfg_wdata[5]. A write with cfg_be[0] low leaves the bit unchanged.
- R4: While the write-enable bit is 0, writes to the identifier have no effect, whatever the byte enables.
- R5: While the write-enable bit is 1 and no load is pending, a write to the identifier updates exactly the bytes whose cfg_be bit is high. Byte i is bits [8i+7:8i].
- R6: ee_load_req stays high from reset until a cycle in which ee_load_valid or ee_load_fail is high. It is low from the next cycle on.
- R7: When ee_load_valid is high while a load is pending and ee_load_fail is low, ee_load_data becomes the identifier from the next cycle.
- R8: When ee_load_fail is high while a load is pending, the identifier keeps its reset value of 0. ee_load_fail takes priority over a simultaneous ee_load_valid.
- R9: While a load is pending, identifier writes have no effect, even with the write-enable bit set.
- R10: While suspend is high, a low rst_bus_n changes neither the identifier nor the write-enable bit, and it does not raise ee_load_req again.
- R11: Reads of any other doubleword address return 0. Writes to them change neither the identifier nor the control bit.
- R12: Once the load has finished, further ee_load_valid pulses are ignored until the next effective reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bus_n | input | 1 | Primary bus reset, active low, synchronous, masked by suspend |
| suspend | input | 1 | High masks the bus reset |
| cfg_dwaddr | input | ADDR_W-2 | Configuration doubleword address (byte offset / 4) |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | DATA_W/8 | Byte enables for the write |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| ee_load_req | output | 1 | A serial-memory load is pending |
| ee_load_valid | input | 1 | Load word is present on ee_load_data |
| ee_load_fail | input | 1 | Serial memory absent or read error |
| ee_load_data | input | DATA_W | Identifier word from serial memory |

## Verification
On every cycle the assertions check that the pending-load flag holds or drops exactly as the load handshake dictates and is never raised again outside reset. They also check that a valid load word lands in the identifier, that a failed load leaves it untouched, that a locked or settled identifier never moves, and that an idle read bus is zero. Only the bench scenarios can show the arithmetic of the byte-enable merge across all sixteen patterns, the map of readable addresses, the blocking of writes during a pending load, and the survival of state across a reset masked by suspend.

// File: rtl/subsys_id_pkg.sv
package subsys_id_pkg;

    typedef enum logic {
        LD_PEND = 1'b0,
        LD_DONE = 1'b1
    } ld_state_e;

    typedef struct packed {
        ld_state_e st;
    } ld_regs_t;

    typedef struct packed {
        logic wren;
    } ctrl_regs_t;

endpackage

// File: rtl/subsys_load_seq.sv
module subsys_load_seq
    import subsys_id_pkg::*;
(
    input  logic clk,
    input  logic rst_eff,
    input  logic ld_valid,
    input  logic ld_fail,
    output logic ld_pending,
    output logic ld_capture
);

    ld_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        ld_capture = 1'b0;
        if (s_q.st == LD_PEND) begin
            if (ld_fail) begin
                s_d.st = LD_DONE;
            end else if (ld_valid) begin
                s_d.st     = LD_DONE;
                ld_capture = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            s_q.st <= LD_PEND;
        end else begin
            s_q <= s_d;
        end
    end

    assign ld_pending = (s_q.st == LD_PEND);

endmodule

// File: rtl/subsys_id_store.sv
module subsys_id_store #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_eff,
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  load_en,
    input  logic [DATA_W-1:0]     load_data,
    output logic [DATA_W-1:0]     id_q
);

    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] id;
    } id_regs_t;

    id_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_en) begin
            r_d.id = load_data;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_be[b]) begin
                    r_d.id[b*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            r_q.id <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign id_q = r_q.id;

endmodule

// File: rtl/subsys_cfg_decode.sv
module subsys_cfg_decode #(
    parameter int               ADDR_W      = 8,
    parameter int               DATA_W      = 32,
    parameter logic [ADDR_W-1:0] ID_OFFSET   = 8'h40,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h80
) (
    input  logic [ADDR_W-3:0] dwaddr,
    input  logic              rd,
    input  logic [DATA_W-1:0] id_val,
    input  logic [DATA_W-1:0] ctrl_val,
    output logic              id_sel,
    output logic              ctrl_sel,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-3:0] ID_DW   = ID_OFFSET[ADDR_W-1:2];
    localparam logic [ADDR_W-3:0] CTRL_DW = CTRL_OFFSET[ADDR_W-1:2];

    always_comb begin
        id_sel   = (dwaddr == ID_DW);
        ctrl_sel = (dwaddr == CTRL_DW);
        rdata    = '0;
        if (rd) begin
            if (id_sel) begin
                rdata = id_val;
            end else if (ctrl_sel) begin
                rdata = ctrl_val;
            end
        end
    end

endmodule

// File: rtl/subsys_id_regs.sv
module subsys_id_regs
    import subsys_id_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] ID_OFFSET   = 8'h40,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h80,
    parameter int                WREN_BIT    = 5
) (
    input  logic                clk,
    input  logic                rst_bus_n,
    input  logic                suspend,
    input  logic [ADDR_W-3:0]   cfg_dwaddr,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic                ee_load_req,
    input  logic                ee_load_valid,
    input  logic                ee_load_fail,
    input  logic [DATA_W-1:0]   ee_load_data
);

    localparam int WREN_LANE = WREN_BIT / 8;

    logic              rst_eff;
    logic              ld_pending;
    logic              ld_capture;
    logic              id_sel;
    logic              ctrl_sel;
    logic              id_wr_ok;
    logic              wren_q;
    logic [DATA_W-1:0] id_val;
    logic [DATA_W-1:0] ctrl_val;

    ctrl_regs_t c_d, c_q;

    // Suspend masks the primary reset from every register in the block.
    assign rst_eff = ~rst_bus_n & ~suspend;

    subsys_load_seq u_load (
        .clk        (clk),
        .rst_eff    (rst_eff),
        .ld_valid   (ee_load_valid),
        .ld_fail    (ee_load_fail),
        .ld_pending (ld_pending),
        .ld_capture (ld_capture)
    );

    subsys_cfg_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ID_OFFSET   (ID_OFFSET),
        .CTRL_OFFSET (CTRL_OFFSET)
    ) u_dec (
        .dwaddr   (cfg_dwaddr),
        .rd       (cfg_rd),
        .id_val   (id_val),
        .ctrl_val (ctrl_val),
        .id_sel   (id_sel),
        .ctrl_sel (ctrl_sel),
        .rdata    (cfg_rdata)
    );

    assign id_wr_ok = cfg_wr & id_sel & wren_q & ~ld_pending;

    subsys_id_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_eff   (rst_eff),
        .wr_en     (id_wr_ok),
        .wr_be     (cfg_be),
        .wr_data   (cfg_wdata),
        .load_en   (ld_capture),
        .load_data (ee_load_data),
        .id_q      (id_val)
    );

    always_comb begin
        c_d = c_q;
        if (cfg_wr && ctrl_sel && cfg_be[WREN_LANE]) begin
            c_d.wren = cfg_wdata[WREN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            c_q.wren <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wren_q = c_q.wren;

    always_comb begin
        ctrl_val           = '0;
        ctrl_val[WREN_BIT] = wren_q;
    end

    assign ee_load_req = ld_pending;

endmodule

// File: rtl/subsys_id_regs_chk.sv
module subsys_id_regs_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_bus_n,
    input logic              suspend,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              ee_load_req,
    input logic              ee_load_valid,
    input logic              ee_load_fail,
    input logic [DATA_W-1:0] ee_load_data,
    input logic [DATA_W-1:0] id_val,
    input logic              wren_q
);

    logic rst_eff;
    assign rst_eff = ~rst_bus_n & ~suspend;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst_eff)
        (ee_load_req && !ee_load_valid && !ee_load_fail) |=> ee_load_req); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst_eff)
        (ee_load_req && (ee_load_valid || ee_load_fail)) |=> !ee_load_req); // R6

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst_eff)
        !ee_load_req |=> !ee_load_req); // R12

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst_eff)
        (ee_load_req && ee_load_valid && !ee_load_fail) |=> (id_val == $past(ee_load_data))); // R7

    AST_FAIL_KEEP: assert property (@(posedge clk) disable iff (rst_eff)
        (ee_load_req && ee_load_fail) |=> (id_val == '0)); // R8

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst_eff)
        (!wren_q && !ee_load_req) |=> $stable(id_val)); // R4

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst_eff)
        (suspend && !rst_bus_n && !cfg_wr && !ee_load_req) |=> ($stable(id_val) && $stable(wren_q))); // R10

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst_eff)
        !cfg_rd |-> (cfg_rdata == '0)); // R2

endmodule

bind subsys_id_regs subsys_id_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_bus_n     (rst_bus_n),
    .suspend       (suspend),
    .cfg_rd        (cfg_rd),
    .cfg_wr        (cfg_wr),
    .cfg_rdata     (cfg_rdata),
    .ee_load_req   (ee_load_req),
    .ee_load_valid (ee_load_valid),
    .ee_load_fail  (ee_load_fail),
    .ee_load_data  (ee_load_data),
    .id_val        (id_val),
    .wren_q        (wren_q)
);

// File: tb/subsys_id_regs_test.sv
`timescale 1ns/1ps
module subsys_id_regs_test;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [5:0] DW_ID   = 6'h10;
    localparam logic [5:0] DW_CTRL = 6'h20;

    logic              clk = 1'b0;
    logic              rst_bus_n = 1'b0;
    logic              suspend = 1'b0;
    logic [5:0]        cfg_dwaddr = '0;
    logic              cfg_rd = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              ee_load_req;
    logic              ee_load_valid = 1'b0;
    logic              ee_load_fail = 1'b0;
    logic [31:0]       ee_load_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_id;

    always #10 clk = ~clk;

    subsys_id_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk           (clk),
        .rst_bus_n     (rst_bus_n),
        .suspend       (suspend),
        .cfg_dwaddr    (cfg_dwaddr),
        .cfg_rd        (cfg_rd),
        .cfg_wr        (cfg_wr),
        .cfg_be        (cfg_be),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .ee_load_req   (ee_load_req),
        .ee_load_valid (ee_load_valid),
        .ee_load_fail  (ee_load_fail),
        .ee_load_data  (ee_load_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_dwaddr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
        cfg_dwaddr = a; cfg_rd = 1'b1;
        #1;
        check(tag, cfg_rdata, exp);
        cfg_rd = 1'b0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    initial begin : watchdog
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        rst_bus_n = 1'b0;
        tick(); tick();
        rst_bus_n = 1'b1;
        // R1 reset state
        check("R1 load req after reset", {31'd0, ee_load_req}, 32'd1);
        cfg_check("R1 id after reset", DW_ID, 32'h0);
        cfg_check("R1 ctrl after reset", DW_CTRL, 32'h0);

        // R9 writes blocked while load pending, even with enable set
        cfg_write(DW_CTRL, 4'h1, 32'h20);
        cfg_check("R3 enable set", DW_CTRL, 32'h20);
        cfg_write(DW_ID, 4'hF, 32'hDEADBEEF);
        cfg_check("R9 id during pending load", DW_ID, 32'h0);
        check("R6 req held", {31'd0, ee_load_req}, 32'd1);

        // R7 load capture
        ee_load_data = 32'h5A5A1234; ee_load_valid = 1'b1;
        tick();
        ee_load_valid = 1'b0;
        check("R6 req dropped", {31'd0, ee_load_req}, 32'd0);
        cfg_check("R7 loaded id", DW_ID, 32'h5A5A1234);
        check("R2 vendor half", {16'd0, cfg_rdata[15:0]}, 32'h1234);
        exp_id = 32'h5A5A1234;

        // R12 second load ignored
        ee_load_data = 32'h11112222; ee_load_valid = 1'b1;
        tick();
        ee_load_valid = 1'b0;
        cfg_check("R12 no reload", DW_ID, exp_id);

        // R3 control register behaviour
        cfg_write(DW_CTRL, 4'hE, 32'h0);
        cfg_check("R3 be0 low keeps bit", DW_CTRL, 32'h20);
        cfg_write(DW_CTRL, 4'hF, 32'h0);
        cfg_check("R3 cleared", DW_CTRL, 32'h0);

        // R4 sweep all byte enables while locked
        for (int k = 0; k < 16; k++) begin
            cfg_write(DW_ID, 4'(k), 32'h9E3779B9 ^ (32'(k) * 32'h01010101));
            cfg_check("R4 locked write", DW_ID, exp_id);
        end

        cfg_write(DW_CTRL, 4'hF, 32'hFFFFFFFF);
        cfg_check("R3 only bit5 readable", DW_CTRL, 32'h20);

        // R5 sweep all byte enables while enabled
        for (int k = 0; k < 16; k++) begin
            logic [31:0] d = 32'hC3A55A3C + (32'(k) * 32'h0F1E2D3B);
            cfg_write(DW_ID, 4'(k), d);
            exp_id = merge(exp_id, d, 4'(k));
            cfg_check("R5 byte-enable write", DW_ID, exp_id);
        end

        // R11 other addresses read 0, writes there inert
        for (int a = 0; a < 64; a++) begin
            if (6'(a) != DW_ID && 6'(a) != DW_CTRL) begin
                cfg_write(6'(a), 4'hF, 32'hFFFFFFFF);
                cfg_check("R11 unmapped read", 6'(a), 32'h0);
            end
        end
        cfg_check("R11 id untouched", DW_ID, exp_id);
        cfg_check("R11 ctrl untouched", DW_CTRL, 32'h20);

        // R2 idle read bus is zero
        cfg_dwaddr = DW_ID; cfg_rd = 1'b0; #1;
        check("R2 rdata with rd low", cfg_rdata, 32'h0);

        // R10 reset masked by suspend
        suspend = 1'b1;
        rst_bus_n = 1'b0;
        tick(); tick(); tick();
        rst_bus_n = 1'b1;
        tick();
        suspend = 1'b0;
        cfg_check("R10 id survives", DW_ID, exp_id);
        cfg_check("R10 enable survives", DW_CTRL, 32'h20);
        check("R10 no new load", {31'd0, ee_load_req}, 32'd0);

        // R1 effective reset, then R8 fail with simultaneous valid
        rst_bus_n = 1'b0;
        tick();
        rst_bus_n = 1'b1;
        check("R1 req after second reset", {31'd0, ee_load_req}, 32'd1);
        cfg_check("R1 id cleared", DW_ID, 32'h0);
        cfg_check("R1 enable cleared", DW_CTRL, 32'h0);
        ee_load_data = 32'hABCDEF01; ee_load_valid = 1'b1; ee_load_fail = 1'b1;
        tick();
        ee_load_valid = 1'b0; ee_load_fail = 1'b0;
        check("R8 req dropped on fail", {31'd0, ee_load_req}, 32'd0);
        cfg_check("R8 id stays zero", DW_ID, 32'h0);
        ee_load_valid = 1'b1;
        tick();
        ee_load_valid = 1'b0;
        cfg_check("R12 valid after fail ignored", DW_ID, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule